// File: doc/BRIEF.md
# SAR converter serial output sequencer

This block is the digital side of a 16-bit successive-approximation converter that talks over a 3-wire serial port. An active-low chip select and a data clock arrive from the host. A comparator decision comes from the analog section. The block samples both pins into its own system clock and counts falling data-clock edges from the moment chip select drops.

The first edges cover the input sample phase. One low null bit follows. Each falling edge after that resolves one bit of the trial register and puts it on the serial line at once, so there is no pipeline delay. After the last bit the word is played back starting from the low end, and then the line floats.

A test mode replaces the analog comparator with a digital compare against a 16-bit code. In that mode a full conversion reproduces the code exactly, which makes the port testable without the analog section. Raising chip select at any time ends the cycle and puts the block in full power-down. A separate flag reports when only the analog part is idle.

Top module: `sar_seq_top`

## Requirements
- R1: A conversion starts only when chip select goes from high to low. Falling data-clock edges while chip select is high, or after a finished conversion while chip select stays low, start nothing, and `sdo_oe` stays 0.
- R2: During the first four falling data-clock edges after the start, `sdo_oe` is 0.
- R3: From the fifth falling edge, `sdo_oe` is 1 and `sdo` carries a 0 null bit for one data-clock period.
- R4: On falling edges 6 to 21, `sdo` carries result bits B15 down to B0, one per edge. Each bit appears within three system clocks of the edge that decides it.
- R5: On falling edges 22 to 36, `sdo` carries B1 up to B15. From edge 37 onward `sdo_oe` is 0, and further edges change nothing.
- R6: Within three system clocks of chip select going high, `sdo_oe` is 0 and `full_pd` is 1, whatever edge the conversion had reached. Reset leaves `sdo_oe` at 0 and both power-down flags at 1 while chip select is high.
- R7: With `test_mode`=1 the result is the 16-bit two's complement value of `test_code`. The end points are 0x7FFF (positive full scale), 0x0000 (zero), 0xFFFF (one step below zero) and 0x8000 (negative full scale).
- R8: With `test_mode`=0, `cmp_in`=1 at a deciding edge keeps the trial bit. The output bit is the inverse of `cmp_in` for B15 and equal to `cmp_in` for B14 to B0.
- R9: `analog_pd` is 0 from the start through edge 20. It is 1 from edge 21 (B0 decided) on, and whenever no conversion is running. `full_pd` is 1 exactly while the synchronised chip select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Chip select, active low. High means shutdown |
| dclk | input | 1 | Serial data clock, idle high |
| cmp_in | input | 1 | Comparator decision from the analog section |
| test_mode | input | 1 | 1 selects the digital stand-in comparator |
| test_code | input | 16 | Two's complement code the stand-in comparator converts |
| sdo | output | 1 | Serial data, high impedance when not enabled |
| sdo_oe | output | 1 | Serial data driver enable |
| full_pd | output | 1 | Full power-down (chip select high) |
| analog_pd | output | 1 | Analog section idle |

## Verification
The assertions assume that chip select and the data clock are slow against `clk`. Each level must hold for several system clocks, so that the two-stage synchroniser sees each edge once. A chip select fall and a data-clock fall must not land in the same system clock. They also assume that `test_code` and `cmp_in` are steady around each deciding edge. The stimulus holds every data-clock half period for eight system clocks and moves chip select only while the data clock is high and has been steady. It changes `cmp_in` and `test_code` only in the middle of the high half, away from any falling edge.

// File: rtl/sar_seq_pkg.sv
// Shared types for the serial output sequencer.
// Assumes: nothing beyond IEEE 1800-2017.
package sar_seq_pkg;

    // Meaning of a falling-edge count for the serial line.
    typedef enum logic [2:0] {
        PH_IDLE,
        PH_SAMPLE,
        PH_NULL,
        PH_RESOLVE,
        PH_REPLAY,
        PH_DONE
    } phase_e;

endpackage

// File: rtl/sar_seq_sync.sv
// Two-stage synchroniser with falling-edge detect for slow asynchronous pins.
// Assumes: each pin level is held for at least three clk periods.
module sar_seq_sync #(
    parameter int WIDTH   = 2,
    parameter bit RST_VAL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin,
    output logic [WIDTH-1:0] level,
    output logic [WIDTH-1:0] fall
);
    logic [WIDTH-1:0] stage1, stage2, stage3;

    // Resynchronise the pins and keep one older copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= {WIDTH{RST_VAL}};
            stage2 <= {WIDTH{RST_VAL}};
            stage3 <= {WIDTH{RST_VAL}};
        end else begin
            stage1 <= pin;
            stage2 <= stage1;
            stage3 <= stage2;
        end
    end

    assign level = stage2;
    assign fall  = stage3 & ~stage2;

endmodule

// File: rtl/sar_seq_reg.sv
// Successive-approximation trial register with the result word it builds.
// Sets the trial bit one data-clock edge before deciding it. Keeps the bit
// when the decision is 1. Stores each output bit as it is resolved.
// Assumes: load and decide never share a cycle. bit_idx is valid while decide is high.
module sar_seq_reg #(
    parameter int WIDTH = 16,
    localparam int IW   = $clog2(WIDTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic             decide,
    input  logic [IW-1:0]    bit_idx,
    input  logic             cmp_ext,
    input  logic             test_mode,
    input  logic [WIDTH-1:0] test_code,
    output logic             live_bit,
    output logic [WIDTH-1:0] result
);
    localparam logic [WIDTH-1:0] SIGN = {1'b1, {(WIDTH-1){1'b0}}};

    logic [WIDTH-1:0] trial;
    logic             decision;

    // Stand-in comparator works in offset binary: trial must not exceed the input.
    always_comb begin
        decision = test_mode ? (trial <= (test_code ^ SIGN)) : cmp_ext;
        live_bit = (bit_idx == IW'(WIDTH - 1)) ? ~decision : decision;
    end

    // Trial register and result word, updated at each deciding edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            trial  <= '0;
            result <= '0;
        end else if (load) begin
            trial  <= SIGN;
            result <= '0;
        end else if (decide) begin
            trial[bit_idx]  <= decision;
            if (bit_idx != '0)
                trial[bit_idx - 1'b1] <= 1'b1;
            result[bit_idx] <= live_bit;
        end
    end

    AST_TRIAL_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        decide |-> trial[bit_idx]) else $error("trial bit not armed"); // R8

    AST_LOW_BITS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $past(load) |-> (trial == SIGN)) else $error("load left stale bits"); // R8

endmodule

// File: rtl/sar_seq_ctrl.sv
// Phase counter and serial-line register. Counts falling data-clock edges from
// the chip select fall and saturates at the done count. Selects null bit, live
// bit or replay bit for the output.
// Assumes: cs_fall and dclk_fall never share a cycle.
module sar_seq_ctrl
    import sar_seq_pkg::*;
#(
    parameter int WIDTH        = 16,
    parameter int SAMPLE_EDGES = 5,
    localparam int IW          = $clog2(WIDTH),
    localparam int DATA_LAST   = SAMPLE_EDGES + WIDTH,
    localparam int REPLAY_LAST = SAMPLE_EDGES + 2 * WIDTH - 1,
    localparam int DONE_CNT    = REPLAY_LAST + 1,
    localparam int CW          = $clog2(DONE_CNT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_high,
    input  logic             cs_fall,
    input  logic             dclk_fall,
    input  logic             live_bit,
    input  logic [WIDTH-1:0] result,
    output logic [CW-1:0]    cnt,
    output logic             active,
    output logic             step,
    output logic             sdo_q,
    output logic             sdo_oe_q
);
    logic [CW-1:0] nxt;
    logic [CW-1:0] rep;
    phase_e        nxt_phase;

    // Next count and the phase it stands for.
    always_comb begin
        step = active && dclk_fall && (cnt != CW'(DONE_CNT));
        nxt  = cnt + 1'b1;
        rep  = nxt - CW'(DATA_LAST);
        if (nxt < CW'(SAMPLE_EDGES))       nxt_phase = PH_SAMPLE;
        else if (nxt == CW'(SAMPLE_EDGES)) nxt_phase = PH_NULL;
        else if (nxt <= CW'(DATA_LAST))    nxt_phase = PH_RESOLVE;
        else if (nxt <= CW'(REPLAY_LAST))  nxt_phase = PH_REPLAY;
        else                               nxt_phase = PH_DONE;
    end

    // Phase counter: cleared by chip select high, armed by its fall.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_high) begin
            cnt    <= '0;
            active <= 1'b0;
        end else if (cs_fall) begin
            cnt    <= '0;
            active <= 1'b1;
        end else if (step) begin
            cnt    <= nxt;
        end
    end

    // Serial line register, loaded at each counted edge.
    always_ff @(posedge clk) begin
        if (!rst_n || cs_high || cs_fall) begin
            sdo_q    <= 1'b0;
            sdo_oe_q <= 1'b0;
        end else if (step) begin
            unique case (nxt_phase)
                PH_NULL:    begin sdo_q <= 1'b0;              sdo_oe_q <= 1'b1; end
                PH_RESOLVE: begin sdo_q <= live_bit;          sdo_oe_q <= 1'b1; end
                PH_REPLAY:  begin sdo_q <= result[rep[IW-1:0]]; sdo_oe_q <= 1'b1; end
                default:    begin sdo_q <= 1'b0;              sdo_oe_q <= 1'b0; end
            endcase
        end
    end

    AST_SAMPLE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cnt < CW'(SAMPLE_EDGES)) |-> !sdo_oe_q) else $error("drive in sample"); // R2

    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !cs_high && !cs_fall) |=> ((cnt == $past(cnt)) || (cnt == $past(cnt) + 1'b1)))
        else $error("counter jumped"); // R4

    AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !cs_high && cnt == CW'(DONE_CNT)) |=> (cnt == CW'(DONE_CNT)))
        else $error("counter wrapped"); // R5

    AST_DONE_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(DONE_CNT)) |-> !sdo_oe_q) else $error("drive after replay"); // R5

endmodule

// File: rtl/sar_seq_top.sv
// Device-side sequencer of a serial successive-approximation converter.
// Synchronises chip select and data clock, runs sample, null, resolve and
// replay phases, and reports power-down state.
// Assumes: cs_n and dclk are slow against clk (three or more clk per level).
module sar_seq_top #(
    parameter int WIDTH        = 16,
    parameter int SAMPLE_EDGES = 5,
    localparam int IW          = $clog2(WIDTH),
    localparam int DATA_LAST   = SAMPLE_EDGES + WIDTH,
    localparam int CW          = $clog2(SAMPLE_EDGES + 2 * WIDTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             dclk,
    input  logic             cmp_in,
    input  logic             test_mode,
    input  logic [WIDTH-1:0] test_code,
    output tri               sdo,
    output logic             sdo_oe,
    output logic             full_pd,
    output logic             analog_pd
);
    logic [1:0]       pin_level, pin_fall;
    logic [CW-1:0]    cnt, offs;
    logic             active, step, live_bit, sdo_q;
    logic             load, decide;
    logic [IW-1:0]    bit_idx;
    logic [WIDTH-1:0] result;

    sar_seq_sync #(.WIDTH(2), .RST_VAL(1'b1)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin({cs_n, dclk}),
        .level(pin_level), .fall(pin_fall)
    );

    // Decode which counted edge loads, and which one decides, a trial bit.
    always_comb begin
        offs    = cnt - CW'(SAMPLE_EDGES);
        bit_idx = IW'(WIDTH - 1) - offs[IW-1:0];
        load    = step && (cnt == CW'(SAMPLE_EDGES - 1));
        decide  = step && (cnt >= CW'(SAMPLE_EDGES)) && (cnt < CW'(DATA_LAST));
    end

    sar_seq_reg #(.WIDTH(WIDTH)) u_reg (
        .clk(clk), .rst_n(rst_n), .clear(pin_level[1]),
        .load(load), .decide(decide), .bit_idx(bit_idx),
        .cmp_ext(cmp_in), .test_mode(test_mode), .test_code(test_code),
        .live_bit(live_bit), .result(result)
    );

    sar_seq_ctrl #(.WIDTH(WIDTH), .SAMPLE_EDGES(SAMPLE_EDGES)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_high(pin_level[1]), .cs_fall(pin_fall[1]),
        .dclk_fall(pin_fall[0]), .live_bit(live_bit), .result(result),
        .cnt(cnt), .active(active), .step(step),
        .sdo_q(sdo_q), .sdo_oe_q(sdo_oe)
    );

    assign sdo       = sdo_oe ? sdo_q : 1'bz;
    assign full_pd   = pin_level[1];
    assign analog_pd = !active || (cnt >= CW'(DATA_LAST));

    AST_PD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
        full_pd |=> !sdo_oe) else $error("driving while shut down"); // R6

    AST_ANALOG_ON_WHEN_DRIVING_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        decide |-> !analog_pd) else $error("deciding with analog off"); // R9

endmodule

// File: tb/sar_seq_top_test.sv
// Bench: behavioural per-edge model of the serial frame, checked after each edge.
module sar_seq_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        dclk = 1'b1;
    logic        cmp_in = 1'b0;
    logic        test_mode = 1'b1;
    logic [15:0] test_code = '0;
    tri          sdo;
    logic        sdo_oe, full_pd, analog_pd;
    int          checks = 0;
    int          failures = 0;

    always #5 clk = ~clk;

    sar_seq_top uut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .dclk(dclk), .cmp_in(cmp_in),
        .test_mode(test_mode), .test_code(test_code), .sdo(sdo),
        .sdo_oe(sdo_oe), .full_pd(full_pd), .analog_pd(analog_pd)
    );

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Expected frame: edge n gives the enable and the bit on the line.
    function automatic logic exp_oe(input int n);
        return (n >= 5) && (n <= 36);
    endfunction

    function automatic logic exp_bit(input int n, input logic [15:0] w);
        if (n <= 5)  return 1'b0;
        if (n <= 21) return w[21 - n];
        return w[n - 21];
    endfunction

    function automatic string req_of(input int n);
        if (n < 5)   return "R2";
        if (n == 5)  return "R3";
        if (n <= 21) return "R4";
        return "R5";
    endfunction

    // Run a conversion of w for nedges falling edges (ext: drive cmp_in).
    task automatic convert(input logic [15:0] w, input logic ext, input int nedges, input string tag);
        test_mode = !ext;
        test_code = w;
        cs_n = 1'b0;
        wait_clk(8);
        chk("R9 full_pd low after start", full_pd, 1'b0);
        for (int n = 1; n <= nedges; n++) begin
            if (n >= 6 && n <= 21)
                cmp_in = (n == 6) ? ~w[15] : w[21 - n];
            wait_clk(4);
            dclk = 1'b0;
            wait_clk(8);
            chk({req_of(n), " oe ", tag}, sdo_oe, exp_oe(n));
            if (exp_oe(n))
                chk({req_of(n), ext ? " R8 bit " : " R7 bit ", tag}, sdo, exp_bit(n, w));
            chk({"R9 analog_pd ", tag}, analog_pd, (n >= 21) ? 1'b1 : 1'b0);
            dclk = 1'b1;
            wait_clk(4);
        end
    endtask

    task automatic finish_cs(input string tag);
        cs_n = 1'b1;
        wait_clk(3);
        chk({"R6 oe after cs high ", tag}, sdo_oe, 1'b0);
        chk({"R6 full_pd ", tag}, full_pd, 1'b1);
        chk({"R9 analog_pd idle ", tag}, analog_pd, 1'b1);
        wait_clk(8);
    endtask

    task automatic idle_edges(input int k, input string tag);
        for (int i = 0; i < k; i++) begin
            dclk = 1'b0;
            wait_clk(8);
            chk({"R1 no start ", tag}, sdo_oe, 1'b0);
            dclk = 1'b1;
            wait_clk(8);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_clk(4);
        rst_n = 1'b1;
        wait_clk(4);
        chk("R6 reset oe", sdo_oe, 1'b0);
        chk("R6 reset full_pd", full_pd, 1'b1);
        chk("R9 reset analog_pd", analog_pd, 1'b1);

        idle_edges(6, "cs high");                 // R1 edges while shut down
        convert(16'h7FFF, 1'b0, 42, "pos full");  // R7 plus R5 extra edges
        idle_edges(4, "after done");              // R1 no restart without cs high
        finish_cs("pos full");
        convert(16'h0000, 1'b0, 37, "zero");      finish_cs("zero");
        convert(16'hFFFF, 1'b0, 37, "minus one"); finish_cs("minus one");
        convert(16'h8000, 1'b0, 37, "neg full");  finish_cs("neg full");
        convert(16'hA5C3, 1'b0, 37, "mixed");     finish_cs("mixed");
        convert(16'h3C5A, 1'b1, 37, "ext cmp");   finish_cs("ext cmp");
        convert(16'h5A5A, 1'b0, 12, "short");     finish_cs("short"); // R6 short cycle
        convert(16'h1234, 1'b0, 37, "restart");   finish_cs("restart"); // R1 clean restart
        convert(16'hC0DE, 1'b1, 8, "short ext");  finish_cs("short ext");

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule